// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is a single synchronisation cell that holds an unsigned count and is shared by a set of requesters. Each access carries a four-bit view code that selects what the access does. Reading through one of the two semaphore views is a wait (take) operation: it returns the count as it stood before the access and takes one unit when the count is non-zero. Writing through either semaphore view is a signal (give) operation: it adds one unit, up to a saturation limit, and ignores the written data.

The wait operation comes in a blocking flavour and a non-blocking flavour. A blocking take on an empty cell does not complete. The cell answers with a block response and notes the requester in a waiter set. The next give releases every noted requester at once through a one-cycle wake vector. The requester then retries. The cell also has a raw view that returns the count with no side effect, and a tag view through which a queue-mode flag can be read and written. When that flag is set, the semaphore views are inert. The port set is the same as the one used by the queue-type cells, so the same decoder can drive both kinds.

Every strobe gets exactly one registered response on the following clock cycle.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is zero and the queue-mode flag is clear, so a raw-view read (view 0) returns 0 and a tag-view read (view 1) returns 0.
- R2: A read through the blocking take view (view 4) or the non-blocking take view (view 5), with the queue-mode flag clear, returns the count as it was before the access (zero-extended) and lowers the count by one when it was non-zero.
- R3: A read through view 4 while the count is zero and the queue-mode flag is clear answers with `block` instead of `done`, returns 0, leaves the count unchanged, and sets bit `req_id` of the waiter set.
- R4: A read through view 5 while the count is zero completes with `done`, returns 0 and leaves the count unchanged.
- R5: A write through view 4 or view 5, with the queue-mode flag clear, raises the count by one and saturates at all ones of the count width (0xFFFF by default). The write data has no effect, and the two views behave the same.
- R6: Every give of R5 drives `wake` for exactly one cycle, with the value the waiter set held just before the give, and then empties the waiter set.
- R7: A tag-view write loads the queue-mode flag from `wdata` bit 17. A tag-view read returns the flag in bit 17 and zeros elsewhere. While the flag is set, reads through views 4 and 5 complete with 0 and change nothing, and writes through views 4 and 5 change nothing and wake no one.
- R8: A raw-view read has no side effect. A raw-view write has no effect.
- R9: Each cycle with `rd_stb` or `wr_stb` high is followed, one cycle later, by exactly one of `done` or `block`. No response follows an idle cycle. When both strobes are high, only the read is performed.
- R10: A read through the queue views (2 and 3) returns 0. A read through an unassigned view (6 to 15) returns all ones. Writes through any of these views have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read access strobe |
| wr_stb | input | 1 | Write access strobe |
| view | input | 4 | View code of the access |
| req_id | input | REQ_W | Identity of the requester |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid with done or block, zero otherwise |
| done | output | 1 | Access completed |
| block | output | 1 | Blocking take refused; requester recorded |
| wake | output | NUM_REQ | One-cycle release of recorded requesters |

## Verification
The bench builds the cell with a four-bit count and four requesters, and keeps the 32-bit data width. The narrow count puts saturation within a few accesses, so the clamp, and the take that follows it, are exercised many times in both directed and random traffic. With four requesters, the random mix of blocking takes on an empty cell builds up waiter sets with several bits set, and every give checks the full wake vector.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

    typedef enum logic [3:0] {
        VW_RAW      = 4'd0,
        VW_TAG      = 4'd1,
        VW_Q_WAIT   = 4'd2,
        VW_Q_TRY    = 4'd3,
        VW_SEM_WAIT = 4'd4,
        VW_SEM_TRY  = 4'd5
    } view_e;

    // bit of the tag word that carries the queue-mode flag
    localparam int MODE_BIT = 17;

    typedef struct packed {
        logic raw;
        logic tag;
        logic queue;
        logic sem;
        logic may_wait;
        logic unused;
    } view_dec_t;

endpackage

// File: rtl/sem_view_decode.sv
module sem_view_decode
    import sem_cell_pkg::*;
(
    input  logic [3:0] view_i,
    output view_dec_t  dec_o
);
    always_comb begin
        dec_o = '0;
        case (view_i)
            VW_RAW:      dec_o.raw = 1'b1;
            VW_TAG:      dec_o.tag = 1'b1;
            VW_Q_WAIT,
            VW_Q_TRY:    dec_o.queue = 1'b1;
            VW_SEM_WAIT: begin
                dec_o.sem      = 1'b1;
                dec_o.may_wait = 1'b1;
            end
            VW_SEM_TRY:  dec_o.sem = 1'b1;
            default:     dec_o.unused = 1'b1;
        endcase
    end
endmodule

// File: rtl/sem_count_step.sv
module sem_count_step #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             up_i,
    input  logic             down_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_comb begin
        zero_o = (cnt_i == '0);
        cnt_o  = cnt_i;
        if (up_i && (cnt_i != CNT_MAX)) begin
            cnt_o = cnt_i + 1'b1;
        end else if (down_i && !zero_o) begin
            cnt_o = cnt_i - 1'b1;
        end
    end
endmodule

// File: rtl/sem_waiter_set.sv
module sem_waiter_set #(
    parameter int NUM_REQ = 8,
    parameter int REQ_W   = 3
) (
    input  logic [NUM_REQ-1:0] mask_i,
    input  logic               add_i,
    input  logic [REQ_W-1:0]   id_i,
    input  logic               clear_i,
    output logic [NUM_REQ-1:0] mask_o
);
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_bit
        logic hit;
        assign hit       = add_i && (id_i == REQ_W'(g));
        assign mask_o[g] = clear_i ? 1'b0 : (mask_i[g] | hit);
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_cell_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int NUM_REQ = 8,
    localparam int REQ_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_stb,
    input  logic               wr_stb,
    input  logic [3:0]         view,
    input  logic [REQ_W-1:0]   req_id,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               done,
    output logic               block,
    output logic [NUM_REQ-1:0] wake
);
    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic               mode;
        logic [NUM_REQ-1:0] waiters;
        logic [DATA_W-1:0]  rdata;
        logic               done;
        logic               block;
        logic [NUM_REQ-1:0] wake;
    } state_t;

    state_t st_d, st_q;

    view_dec_t          dec;
    logic               rd_go, wr_go;
    logic               take_go, take_block, give_go;
    logic               cnt_zero;
    logic [CNT_W-1:0]   cnt_next;
    logic [NUM_REQ-1:0] mask_next;

    sem_view_decode u_dec (
        .view_i (view),
        .dec_o  (dec)
    );

    // read wins when both strobes are raised together
    assign rd_go      = rd_stb;
    assign wr_go      = wr_stb && !rd_stb;
    assign take_go    = rd_go && dec.sem && !st_q.mode;
    assign take_block = take_go && dec.may_wait && cnt_zero;
    assign give_go    = wr_go && dec.sem && !st_q.mode;

    sem_count_step #(.CNT_W(CNT_W)) u_cnt (
        .cnt_i  (st_q.cnt),
        .up_i   (give_go),
        .down_i (take_go),
        .cnt_o  (cnt_next),
        .zero_o (cnt_zero)
    );

    sem_waiter_set #(.NUM_REQ(NUM_REQ), .REQ_W(REQ_W)) u_wait (
        .mask_i  (st_q.waiters),
        .add_i   (take_block),
        .id_i    (req_id),
        .clear_i (give_go),
        .mask_o  (mask_next)
    );

    always_comb begin
        st_d         = st_q;
        st_d.cnt     = cnt_next;
        st_d.waiters = mask_next;
        st_d.rdata   = '0;
        st_d.done    = 1'b0;
        st_d.block   = 1'b0;
        st_d.wake    = '0;
        if (rd_go) begin
            st_d.done  = !take_block;
            st_d.block = take_block;
            if (dec.raw) begin
                st_d.rdata = DATA_W'(st_q.cnt);
            end else if (dec.tag) begin
                st_d.rdata[MODE_BIT] = st_q.mode;
            end else if (dec.sem) begin
                if (!st_q.mode) begin
                    st_d.rdata = DATA_W'(st_q.cnt);
                end
            end else if (dec.unused) begin
                st_d.rdata = '1;
            end
        end else if (wr_go) begin
            st_d.done = 1'b1;
            if (dec.tag) begin
                st_d.mode = wdata[MODE_BIT];
            end
            if (give_go) begin
                st_d.wake = st_q.waiters;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign done  = st_q.done;
    assign block = st_q.block;
    assign wake  = st_q.wake;

endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk #(
    parameter int DATA_W  = 32,
    parameter int NUM_REQ = 8,
    parameter int REQ_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_stb,
    input logic               wr_stb,
    input logic [3:0]         view,
    input logic [DATA_W-1:0]  rdata,
    input logic               done,
    input logic               block,
    input logic [NUM_REQ-1:0] wake
);
    a_r9_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && block));

    a_r9_answer_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |=> (done || block));

    a_r9_silent_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb || wr_stb) |=> !(done || block));

    a_r3_block_from_wait_read: assert property (@(posedge clk) disable iff (!rst_n)
        block |-> $past(rd_stb && (view == 4'd4)));

    a_r3_block_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        block |-> (rdata == '0));

    a_r6_wake_after_give: assert property (@(posedge clk) disable iff (!rst_n)
        (wake != '0) |-> $past(wr_stb && !rd_stb && ((view == 4'd4) || (view == 4'd5))));

    a_r6_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (wake != '0) |=> (wake == '0));
endmodule

bind sem_cell sem_cell_chk #(
    .DATA_W  (DATA_W),
    .NUM_REQ (NUM_REQ),
    .REQ_W   (REQ_W)
) u_sem_cell_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (rd_stb),
    .wr_stb (wr_stb),
    .view   (view),
    .rdata  (rdata),
    .done   (done),
    .block  (block),
    .wake   (wake)
);

// File: tb/test_sem_cell.sv
module test_sem_cell;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 4;
    localparam int NUM_REQ = 4;
    localparam int REQ_W   = 2;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rd_stb = 1'b0;
    logic               wr_stb = 1'b0;
    logic [3:0]         view = '0;
    logic [REQ_W-1:0]   req_id = '0;
    logic [DATA_W-1:0]  wdata = '0;
    logic [DATA_W-1:0]  rdata;
    logic               done;
    logic               block;
    logic [NUM_REQ-1:0] wake;

    int checks = 0;
    int fails  = 0;

    // bench model
    int                 m_cnt  = 0;
    logic               m_mode = 1'b0;
    logic [NUM_REQ-1:0] m_wait = '0;

    always #5 clk = ~clk;

    sem_cell #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_REQ(NUM_REQ)) i_sem_cell (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .view(view), .req_id(req_id), .wdata(wdata), .rdata(rdata),
        .done(done), .block(block), .wake(wake)
    );

    function automatic string tag_of(input logic rd, input logic [3:0] v);
        if (v == 4'd0) return "R8";
        if (v == 4'd1) return "R7";
        if (v == 4'd2 || v == 4'd3 || v > 4'd5) return "R10";
        if (rd) return (v == 4'd4) ? "R3" : "R2";
        return "R5";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic wr, input logic [3:0] v,
                          input logic [REQ_W-1:0] id, input logic [DATA_W-1:0] wd,
                          input string tag);
        logic [DATA_W-1:0]  e_rd;
        logic               e_done, e_block;
        logic [NUM_REQ-1:0] e_wake;
        logic               is_sem;
        e_rd = '0; e_done = 1'b0; e_block = 1'b0; e_wake = '0;
        is_sem = (v == 4'd4) || (v == 4'd5);
        if (rd) begin
            e_done = 1'b1;
            if (v == 4'd0) e_rd = DATA_W'(m_cnt);
            else if (v == 4'd1) e_rd[17] = m_mode;
            else if (v > 4'd5) e_rd = '1;
            else if (is_sem && !m_mode) begin
                e_rd = DATA_W'(m_cnt);
                if (m_cnt > 0) m_cnt--;
                else if (v == 4'd4) begin
                    e_done = 1'b0; e_block = 1'b1; m_wait[id] = 1'b1;
                end
            end
        end else if (wr) begin
            e_done = 1'b1;
            if (v == 4'd1) m_mode = wd[17];
            else if (is_sem && !m_mode) begin
                if (m_cnt < CNT_MAX) m_cnt++;
                e_wake = m_wait;
                m_wait = '0;
            end
        end
        @(negedge clk);
        rd_stb = rd; wr_stb = wr; view = v; req_id = id; wdata = wd;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        check(tag, "rdata", 64'(rdata), 64'(e_rd));
        check(tag, "done",  64'(done),  64'(e_done));
        check(tag, "block", 64'(block), 64'(e_block));
        check(tag, "wake",  64'(wake),  64'(e_wake));
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "done idle", 64'(done), 64'd0);
        access(1, 0, 4'd0, 0, 0, "R1");
        access(1, 0, 4'd1, 0, 0, "R1");
        // R4 non-blocking take on empty cell
        access(1, 0, 4'd5, 2, 0, "R4");
        // R3 blocking takes on empty cell record requesters
        access(1, 0, 4'd4, 1, 0, "R3");
        access(1, 0, 4'd4, 3, 0, "R3");
        access(1, 0, 4'd0, 0, 0, "R3");
        // R5 and R6: give with junk data releases both waiters
        access(0, 1, 4'd4, 0, 32'hDEAD_BEEF, "R6");
        access(0, 1, 4'd5, 0, 32'h0, "R5");
        // R2 take returns value before decrement
        access(1, 0, 4'd4, 0, 0, "R2");
        access(1, 0, 4'd0, 0, 0, "R2");
        // R5 saturation
        for (int i = 0; i < CNT_MAX + 4; i++) access(0, 1, 4'd5, 0, 32'(i), "R5");
        access(1, 0, 4'd0, 0, 0, "R5");
        // R9 both strobes: read only
        access(1, 1, 4'd5, 0, 0, "R9");
        access(1, 0, 4'd0, 0, 0, "R9");
        // R7 queue-mode flag
        access(0, 1, 4'd1, 0, 32'h0002_0000, "R7");
        access(1, 0, 4'd1, 0, 0, "R7");
        access(1, 0, 4'd4, 0, 0, "R7");
        access(0, 1, 4'd4, 0, 0, "R7");
        access(1, 0, 4'd0, 0, 0, "R7");
        access(0, 1, 4'd1, 0, 32'hFFFD_FFFF, "R7");
        access(1, 0, 4'd1, 0, 0, "R7");
        // R8 raw write and R10 other views
        access(0, 1, 4'd0, 0, 32'h5, "R8");
        access(1, 0, 4'd0, 0, 0, "R8");
        access(1, 0, 4'd2, 0, 0, "R10");
        access(1, 0, 4'd3, 0, 0, "R10");
        access(1, 0, 4'd9, 0, 0, "R10");
        access(0, 1, 4'd15, 0, 32'h1234, "R10");
        access(0, 1, 4'd2, 0, 32'h1234, "R10");
        access(1, 0, 4'd0, 0, 0, "R10");

        // random traffic
        for (int i = 0; i < 1500; i++) begin
            int unsigned r, k;
            logic [3:0] v;
            logic rd, wr;
            r = $urandom % 16;
            if (r < 5) v = 4'd4;
            else if (r < 9) v = 4'd5;
            else if (r < 11) v = 4'd0;
            else if (r < 12) v = 4'd1;
            else if (r < 13) v = 4'd2;
            else if (r < 14) v = 4'd11;
            else v = 4'd4;
            k = $urandom % 16;
            rd = (k < 7) || (k == 15);
            wr = (k >= 7);
            access(rd, wr, v, REQ_W'($urandom), $urandom, tag_of(rd, v));
            if ((i % 5) == 0) begin
                @(negedge clk);
                check("R9", "idle done", 64'(done), 64'd0);
                check("R9", "idle block", 64'(block), 64'd0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule